// File: doc/BRIEF.md
# USB Endpoint Data-PID and Stall Tracker

This block holds the per-endpoint sequencing state of a USB device controller. It keeps a 2-bit data PID field and a force-stall request bit. It packs both into a read-only status word, and it tells the protocol engine whether the next handshake is ACK or STALL. The meaning of the PID field depends on the endpoint. On an IN endpoint it is the PID that the next transmitted packet will carry. On an OUT or control endpoint it is the PID of the data held in the bank that software is currently reading.

For IN traffic the protocol engine reports each acknowledged packet together with the PID it carried, and the block works out the next PID. Bulk and interrupt endpoints alternate between DATA0 and DATA1. High-bandwidth isochronous endpoints step down DATA2 → DATA1 → DATA0. For OUT traffic the block records the PID of every packet stored into a bank. It keeps these in arrival order across `NB` banks, so the field follows the current bank as software releases banks one after another. Software strobes force the field back to DATA1, disable the endpoint, or request a stall. A received SETUP withdraws the stall request.

Top module: `ep_trk_top`

## Requirements
- R1: After reset, `ep_status` reads 0x40 (PID field DATA1, stall bit 0), `hs_stall` is 0 and `out_bank_busy` is 0.
- R2: `ep_status` bits 7:6 hold the PID field, encoded 00=DATA0, 01=DATA1, 10=DATA2, 11=MDATA. Bit 5 holds the stall request and equals `hs_stall`. All other bits read 0.
- R3: In IN mode (`ep_is_in`=1 and `ep_kind`≠00), on a non-isochronous endpoint, a `tx_ack` makes the field DATA1 in the next cycle when `tx_pid` was DATA0, and DATA0 otherwise.
- R4: In IN mode on an isochronous endpoint (`ep_kind`=01), a `tx_ack` behaves as follows. With `hb_iso`=1 the field steps DATA2→DATA1, DATA1→DATA0, and any other PID→DATA0. With `hb_iso`=0 the field always becomes DATA0.
- R5: In OUT mode (`ep_is_in`=0 or `ep_kind`=00 control), an `rx_wr` that is stored while no bank is busy loads `rx_pid` into the field in the next cycle and sets `out_bank_busy`.
- R6: In OUT mode, a `bank_release` while a bank is busy frees the oldest bank. The field then shows the PID of the next busy bank. If no bank remains busy, the field holds its value and `out_bank_busy` falls.
- R7: In OUT mode, an `rx_wr` that arrives while all `NB` banks are busy is dropped. The field and the later bank sequence do not change.
- R8: DATA2 and MDATA are accepted by `rx_wr` only when `ep_kind`=01 and `hb_iso`=1. On any other endpoint such a write is dropped.
- R9: `tx_ack` has no effect in OUT mode, and `rx_wr` and `bank_release` have no effect in IN mode.
- R10: `toggle_clr` or `ep_disable` sets the field to DATA1 in the next cycle, overriding any same-cycle update. `ep_disable` also empties all banks and drops a same-cycle `rx_wr`.
- R11: `stall_req` sets the stall bit, so `hs_stall`=1 (STALL) from the next cycle. `setup_seen` clears it, and `setup_seen` wins when both arrive in the same cycle.
- R12: When `setup_seen` and `toggle_clr` arrive in the same cycle, the next cycle shows field DATA1 and the stall bit cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_kind | input | 2 | Endpoint type: 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| ep_is_in | input | 1 | 1 = IN (device to host) endpoint |
| hb_iso | input | 1 | 1 = high-bandwidth isochronous endpoint |
| tx_ack | input | 1 | Strobe: an IN packet was acknowledged |
| tx_pid | input | 2 | PID carried by the acknowledged IN packet |
| rx_wr | input | 1 | Strobe: an OUT/SETUP data packet is offered to a bank |
| rx_pid | input | 2 | PID of the offered packet |
| bank_release | input | 1 | Software strobe: current OUT bank has been read |
| setup_seen | input | 1 | Strobe: a SETUP token was received |
| stall_req | input | 1 | Software strobe: request a STALL handshake |
| toggle_clr | input | 1 | Software strobe: force the PID field to DATA1 |
| ep_disable | input | 1 | Software strobe: disable the endpoint |
| ep_status | output | STAT_W | Read-only status word |
| hs_stall | output | 1 | Next handshake: 1 = STALL, 0 = ACK |
| out_bank_busy | output | 1 | At least one OUT bank holds data |

## Verification
Some properties are checked by the assertions on every cycle. These are the layout of the status word, forcing DATA1 after a clear or a disable, the stall set/clear priority, IN alternation on non-isochronous endpoints, capture into an empty bank, and the bank count never exceeding `NB`. The bench's scenarios are the only place that shows the cases needing history. These are the order of PIDs across several busy banks, drops when the banks are full, rejection of illegal PIDs, and the descending high-bandwidth isochronous IN sequence. The bench also shows that events from the inactive direction leave the state untouched.

// File: rtl/ep_trk_pkg.sv
package ep_trk_pkg;
  localparam logic [1:0] PID_D0 = 2'd0;
  localparam logic [1:0] PID_D1 = 2'd1;
  localparam logic [1:0] PID_D2 = 2'd2;
  localparam logic [1:0] PID_MD = 2'd3;

  localparam logic [1:0] EPK_CTRL = 2'd0;
  localparam logic [1:0] EPK_ISO  = 2'd1;
  localparam logic [1:0] EPK_BULK = 2'd2;
  localparam logic [1:0] EPK_INTR = 2'd3;

  // DATA2/MDATA only belong to high-bandwidth isochronous endpoints
  function automatic logic pid_allowed(logic [1:0] kind, logic hb, logic [1:0] pid);
    return (pid[1] == 1'b0) || ((kind == EPK_ISO) && hb);
  endfunction

  // PID to use after an acknowledged IN packet
  function automatic logic [1:0] in_next_pid(logic [1:0] kind, logic hb, logic [1:0] sent);
    logic [1:0] nxt;
    if (kind == EPK_ISO) begin
      if (!hb) nxt = PID_D0;
      else if (sent == PID_D2) nxt = PID_D1;
      else nxt = PID_D0;
    end else begin
      nxt = (sent == PID_D0) ? PID_D1 : PID_D0;
    end
    return nxt;
  endfunction

  function automatic logic [7:0] status_byte(logic [1:0] field, logic stall);
    return {field, stall, 5'b00000};
  endfunction
endpackage

// File: rtl/ep_out_banks.sv
module ep_out_banks #(
  parameter int NB = 2,
  localparam int PTR_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int CNT_W = $clog2(NB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [1:0]       wr_pid,
  input  logic             rel_en,
  output logic             accept,
  output logic             front_load,
  output logic [1:0]       front_pid,
  output logic             busy,
  output logic [CNT_W-1:0] count
);
  logic [1:0]       pid_mem [NB];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             rel_do;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(NB - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    accept     = wr_en && (count < CNT_W'(NB));
    rel_do     = rel_en && (count != '0);
    rd_nxt     = rel_do ? ptr_inc(rd_ptr) : rd_ptr;
    cnt_nxt    = count - CNT_W'(rel_do) + CNT_W'(accept);
    front_load = (rel_do || (accept && (count == '0))) && (cnt_nxt != '0);
    front_pid  = (accept && (wr_ptr == rd_nxt)) ? wr_pid : pid_mem[rd_nxt];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < NB; i++) pid_mem[i] <= 2'd0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= rd_nxt;
      count  <= cnt_nxt;
      if (accept) begin
        pid_mem[wr_ptr] <= wr_pid;
        wr_ptr          <= ptr_inc(wr_ptr);
      end
    end
  end

  assign busy = (count != '0);
endmodule

// File: rtl/ep_toggle_reg.sv
module ep_toggle_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       force_d1,
  input  logic       load_en,
  input  logic [1:0] load_pid,
  input  logic       adv_en,
  input  logic [1:0] adv_pid,
  output logic [1:0] field
);
  import ep_trk_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        field <= PID_D1;
    else if (force_d1) field <= PID_D1;
    else if (load_en)  field <= load_pid;
    else if (adv_en)   field <= adv_pid;
  end
endmodule

// File: rtl/ep_stall_ctl.sv
module ep_stall_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic setup_clr,
  output logic stall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stall <= 1'b0;
    else if (setup_clr) stall <= 1'b0;
    else if (set_req)   stall <= 1'b1;
  end
endmodule

// File: rtl/ep_trk_top.sv
module ep_trk_top #(
  parameter int NB     = 2,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ep_kind,
  input  logic              ep_is_in,
  input  logic              hb_iso,
  input  logic              tx_ack,
  input  logic [1:0]        tx_pid,
  input  logic              rx_wr,
  input  logic [1:0]        rx_pid,
  input  logic              bank_release,
  input  logic              setup_seen,
  input  logic              stall_req,
  input  logic              toggle_clr,
  input  logic              ep_disable,
  output logic [STAT_W-1:0] ep_status,
  output logic              hs_stall,
  output logic              out_bank_busy
);
  import ep_trk_pkg::*;

  localparam int CNT_W = $clog2(NB + 1);

  // named internal events
  logic             in_mode;
  logic             in_advance;
  logic [1:0]       in_pid_nxt;
  logic             rx_go;
  logic             rel_go;
  logic             rx_accept;
  logic             bank_load;
  logic [1:0]       bank_pid;
  logic [CNT_W-1:0] bank_cnt;
  logic             force_d1;
  logic [1:0]       field;
  logic             stall_bit;

  assign in_mode    = ep_is_in && (ep_kind != EPK_CTRL);
  assign in_advance = tx_ack && in_mode && !ep_disable;
  assign in_pid_nxt = in_next_pid(ep_kind, hb_iso, tx_pid);
  assign rx_go      = rx_wr && !in_mode && !ep_disable && pid_allowed(ep_kind, hb_iso, rx_pid);
  assign rel_go     = bank_release && !in_mode && !ep_disable;
  assign force_d1   = toggle_clr || ep_disable;

  ep_out_banks #(.NB(NB)) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (ep_disable),
    .wr_en      (rx_go),
    .wr_pid     (rx_pid),
    .rel_en     (rel_go),
    .accept     (rx_accept),
    .front_load (bank_load),
    .front_pid  (bank_pid),
    .busy       (out_bank_busy),
    .count      (bank_cnt)
  );

  ep_toggle_reg u_tgl (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_d1 (force_d1),
    .load_en  (bank_load),
    .load_pid (bank_pid),
    .adv_en   (in_advance),
    .adv_pid  (in_pid_nxt),
    .field    (field)
  );

  ep_stall_ctl u_stall (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_req   (stall_req),
    .setup_clr (setup_seen),
    .stall     (stall_bit)
  );

  always_comb begin
    ep_status      = '0;
    ep_status[7:0] = status_byte(field, stall_bit);
  end

  assign hs_stall = stall_bit;
endmodule

// File: rtl/ep_trk_checker.sv
module ep_trk_checker #(
  parameter int NB     = 2,
  parameter int STAT_W = 32,
  localparam int CNT_W = $clog2(NB + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        ep_kind,
  input logic              in_mode,
  input logic              tx_ack,
  input logic [1:0]        tx_pid,
  input logic [1:0]        rx_pid,
  input logic              setup_seen,
  input logic              stall_req,
  input logic              toggle_clr,
  input logic              ep_disable,
  input logic              rx_accept,
  input logic [CNT_W-1:0]  bank_cnt,
  input logic [1:0]        field,
  input logic [STAT_W-1:0] ep_status,
  input logic              hs_stall,
  input logic              out_bank_busy
);
  AST_STATUS_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_status[5] == hs_stall) && (ep_status[4:0] == 5'd0) && (ep_status[7:6] == field)); // R2
  AST_CLEAR_TO_DATA1: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_clr || ep_disable) |=> (ep_status[7:6] == 2'd1)); // R10
  AST_SETUP_DROPS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    setup_seen |=> !hs_stall); // R11
  AST_STALL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && !setup_seen) |=> hs_stall); // R11
  AST_IN_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && (ep_kind != 2'd1) && tx_ack && !toggle_clr && !ep_disable)
      |=> (ep_status[7:6] == (($past(tx_pid) == 2'd0) ? 2'd1 : 2'd0))); // R3
  AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && (bank_cnt == '0) && !toggle_clr)
      |=> (out_bank_busy && (ep_status[7:6] == $past(rx_pid)))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    bank_cnt <= CNT_W'(NB)); // R7
endmodule

bind ep_trk_top ep_trk_checker #(.NB(NB), .STAT_W(STAT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ep_kind       (ep_kind),
  .in_mode       (in_mode),
  .tx_ack        (tx_ack),
  .tx_pid        (tx_pid),
  .rx_pid        (rx_pid),
  .setup_seen    (setup_seen),
  .stall_req     (stall_req),
  .toggle_clr    (toggle_clr),
  .ep_disable    (ep_disable),
  .rx_accept     (rx_accept),
  .bank_cnt      (bank_cnt),
  .field         (field),
  .ep_status     (ep_status),
  .hs_stall      (hs_stall),
  .out_bank_busy (out_bank_busy)
);

// File: tb/ep_trk_top_tb_top.sv
`timescale 1ns/1ps
module ep_trk_top_tb_top;
  localparam int NB = 2;
  localparam int STAT_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ep_kind = 2'd2;
  logic ep_is_in = 1'b1, hb_iso = 1'b0;
  logic tx_ack = 0, rx_wr = 0, bank_release = 0, setup_seen = 0;
  logic stall_req = 0, toggle_clr = 0, ep_disable = 0;
  logic [1:0] tx_pid = 0, rx_pid = 0;
  logic [STAT_W-1:0] ep_status;
  logic hs_stall, out_bank_busy;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference state
  int m_q[$];
  int m_field = 1;
  bit m_stall = 0;

  always #2.5 clk = ~clk;

  ep_trk_top #(.NB(NB), .STAT_W(STAT_W)) dut_i (.*);

  function automatic bit m_legal(int p);
    return (p < 2) || (ep_kind == 2'd1 && hb_iso);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_field = 1; m_stall = 0;
    end else begin
      bit in_side;
      int nf;
      int old_sz;
      bit take, popped;
      in_side = ep_is_in && (ep_kind != 2'd0);
      if (setup_seen) m_stall = 0;
      else if (stall_req) m_stall = 1;
      nf = m_field;
      if (ep_disable) begin
        m_q.delete();
      end else if (in_side) begin
        if (tx_ack) begin
          if (ep_kind == 2'd1) nf = (hb_iso && tx_pid == 2) ? 1 : 0;
          else nf = (tx_pid == 0) ? 1 : 0;
        end
      end else begin
        old_sz = m_q.size();
        take = rx_wr && m_legal(int'(rx_pid)) && (old_sz < NB);
        popped = 0;
        if (bank_release && old_sz > 0) begin void'(m_q.pop_front()); popped = 1; end
        if (take) m_q.push_back(int'(rx_pid));
        if ((popped || (take && old_sz == 0)) && m_q.size() > 0) nf = m_q[0];
      end
      if (toggle_clr || ep_disable) nf = 1;
      m_field = nf;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_st;
      exp_st = (m_field << 6) | (int'(m_stall) << 5);
      n_tests++;
      if (ep_status != STAT_W'(exp_st) || hs_stall != m_stall || out_bank_busy != (m_q.size() > 0)) begin
        n_fail++;
        $display("FAIL %s per-cycle: status=%h stall=%0b busy=%0b expected status=%h stall=%0b busy=%0b",
                 cur_req, ep_status, hs_stall, out_bank_busy, exp_st, m_stall, m_q.size() > 0);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one-cycle strobe helper: bits = {tx,rx,rel,setup,stall,tclr,dis}
  task automatic fire(input logic [6:0] s, input logic [1:0] tp, input logic [1:0] rp);
    {tx_ack, rx_wr, bank_release, setup_seen, stall_req, toggle_clr, ep_disable} = s;
    tx_pid = tp; rx_pid = rp;
    @(negedge clk);
    {tx_ack, rx_wr, bank_release, setup_seen, stall_req, toggle_clr, ep_disable} = '0;
  endtask

  function automatic int fld();
    return int'(ep_status[7:6]);
  endfunction

  localparam logic [6:0] S_TX = 7'b1000000, S_RX = 7'b0100000, S_REL = 7'b0010000,
                         S_SU = 7'b0001000, S_ST = 7'b0000100, S_TC = 7'b0000010,
                         S_DI = 7'b0000001;

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 status", int'(ep_status), 32'h40);
    chk("R1 hs_stall", int'(hs_stall), 0);
    chk("R1 busy", int'(out_bank_busy), 0);

    // R3 bulk IN alternation
    cur_req = "R3"; ep_kind = 2'd2; ep_is_in = 1;
    fire(S_TX, 2'd1, 2'd0); chk("R3 after DATA1", fld(), 0);
    fire(S_TX, 2'd0, 2'd0); chk("R3 after DATA0", fld(), 1);
    ep_kind = 2'd3;
    fire(S_TX, 2'd1, 2'd0); chk("R3 interrupt after DATA1", fld(), 0);

    // R4 isochronous IN
    cur_req = "R4"; ep_kind = 2'd1; hb_iso = 1;
    fire(S_TX, 2'd2, 2'd0); chk("R4 hb DATA2->DATA1", fld(), 1);
    fire(S_TX, 2'd1, 2'd0); chk("R4 hb DATA1->DATA0", fld(), 0);
    fire(S_TX, 2'd0, 2'd0); chk("R4 hb DATA0->DATA0", fld(), 0);
    hb_iso = 0; fire(S_TC, 2'd0, 2'd0);
    fire(S_TX, 2'd1, 2'd0); chk("R4 plain iso -> DATA0", fld(), 0);

    // R9 rx and release ignored in IN mode
    cur_req = "R9"; ep_kind = 2'd2;
    fire(S_RX, 2'd0, 2'd1); chk("R9 rx in IN mode busy", int'(out_bank_busy), 0);
    chk("R9 rx in IN mode field", fld(), 0);

    // R5/R7/R6 OUT bulk banks
    cur_req = "R5"; ep_is_in = 0;
    fire(S_RX, 2'd0, 2'd1); chk("R5 capture", fld(), 1);
    chk("R5 busy", int'(out_bank_busy), 1);
    fire(S_RX, 2'd0, 2'd0); chk("R5 second bank keeps front", fld(), 1);
    cur_req = "R7";
    fire(S_RX, 2'd0, 2'd1); chk("R7 full drop field", fld(), 1);
    cur_req = "R9";
    fire(S_TX, 2'd0, 2'd0); chk("R9 tx in OUT mode", fld(), 1);
    cur_req = "R6";
    fire(S_REL, 2'd0, 2'd0); chk("R6 next bank pid", fld(), 0);
    chk("R7 dropped write never surfaced (still busy one bank)", int'(out_bank_busy), 1);
    fire(S_REL, 2'd0, 2'd0); chk("R6 empty holds field", fld(), 0);
    chk("R6 busy falls", int'(out_bank_busy), 0);
    // release and write together with one bank busy
    fire(S_RX, 2'd0, 2'd1); chk("R5 capture DATA1", fld(), 1);
    fire(S_RX | S_REL, 2'd0, 2'd0); chk("R6 swap in same cycle", fld(), 0);
    fire(S_REL, 2'd0, 2'd0); chk("R6 drained", int'(out_bank_busy), 0);

    // R8 illegal PID handling
    cur_req = "R8";
    fire(S_RX, 2'd0, 2'd2); chk("R8 DATA2 on bulk dropped", int'(out_bank_busy), 0);
    ep_kind = 2'd1; hb_iso = 1;
    fire(S_RX, 2'd0, 2'd3); chk("R8 MDATA on hb iso", fld(), 3);
    fire(S_REL, 2'd0, 2'd0);
    hb_iso = 0;
    fire(S_RX, 2'd0, 2'd2); chk("R8 DATA2 on plain iso dropped", int'(out_bank_busy), 0);

    // R10 clear and disable
    cur_req = "R10"; ep_kind = 2'd0;
    fire(S_RX, 2'd0, 2'd0); chk("R5 control capture", fld(), 0);
    fire(S_TC, 2'd0, 2'd0); chk("R10 toggle clear", fld(), 1);
    fire(S_RX, 2'd0, 2'd0);
    fire(S_DI | S_RX, 2'd0, 2'd0); chk("R10 disable field", fld(), 1);
    chk("R10 disable empties", int'(out_bank_busy), 0);
    fire(S_TC | S_RX, 2'd0, 2'd0); chk("R10 clear beats capture", fld(), 1);
    chk("R10 write still stored", int'(out_bank_busy), 1);
    fire(S_REL, 2'd0, 2'd0);

    // R11 stall
    cur_req = "R11";
    fire(S_ST, 2'd0, 2'd0); chk("R11 stall set", int'(hs_stall), 1);
    chk("R2 bit5 mirrors", int'(ep_status[5]), 1);
    fire(S_SU, 2'd0, 2'd0); chk("R11 setup clears", int'(hs_stall), 0);
    fire(S_SU | S_ST, 2'd0, 2'd0); chk("R11 setup wins", int'(hs_stall), 0);

    // R12 setup together with toggle clear
    cur_req = "R12";
    fire(S_ST, 2'd0, 2'd0);
    fire(S_RX, 2'd0, 2'd0);
    fire(S_SU | S_TC, 2'd0, 2'd0);
    chk("R12 field", fld(), 1);
    chk("R12 stall", int'(hs_stall), 0);
    cur_req = "R2";
    chk("R2 word", int'(ep_status), 32'h40);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule